// File: doc/BRIEF.md
# Quota-Based Round-Robin Memory Port Arbiter

This block shares one memory-controller command port among up to eight requesters of equal rank. Ownership of the port passes between requesters in circular order. After a requester wins the port, it keeps it for a minimum number of completed transfers. The memory then sees long runs from one source instead of short interleaved pieces. A holder that stops requesting gives the port up at once. A holder that has used its quota keeps the port for as long as nobody else is asking for it.

Each requester drives a request line, a transfer strobe, a burst length and a command (address, write flag, write data). The arbiter forwards the owner's command to the downstream port. It returns the downstream stall to the owner only. A multi-transfer burst is never split: the arbiter will not hand the port to another requester until the last beat of the burst has completed. The grant is a registered one-hot vector, and any change in it becomes visible one clock after the decision.

Top module: `mem_port_arbiter`

## Requirements
- R1: After synchronous reset the grant is one-hot on requester 0 with a full quota, and the downstream valid is low while no strobe is driven.
- R2: The grant vector is one-hot in every cycle.
- R3: When the port moves, the new owner is the first requesting index after the previous owner, searching upward and wrapping from N-1 to 0.
- R4: While the owner keeps requesting and has completed fewer than QUOTA transfers since it was granted, the grant does not change.
- R5: When the owner's request is low, no burst is open and another requester is asking, the grant moves on the next clock.
- R6: An owner that is still requesting keeps the grant past its quota for as long as no other requester asks.
- R7: A completed transfer made while no burst is open starts a burst of m_burst beats (0 is taken as 1). The grant does not change until all of those beats have completed, even when the quota has run out.
- R8: Only completed transfers count toward the quota. A completed transfer is a cycle in which the owner's strobe is high and ds_wait is low, so stalled cycles use no quota.
- R9: When no requester asks, the last grant is held and no command is issued downstream unless the owner strobes.
- R10: m_wait of the owner equals ds_wait; every other bit of m_wait is 1.
- R11: ds_valid equals the owner's strobe, and ds_addr, ds_we, ds_wdata and ds_burst carry the owner's fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | N | Request line per requester |
| m_xfer | input | N | Transfer strobe per requester |
| m_burst | input | N*BW | Burst length per requester, sampled on the first beat |
| m_addr | input | N*AW | Address per requester |
| m_we | input | N | Write flag per requester |
| m_wdata | input | N*DW | Write data per requester |
| m_grant | output | N | One-hot port ownership |
| m_wait | output | N | Stall returned to each requester |
| ds_valid | output | 1 | Downstream command valid |
| ds_addr | output | AW | Downstream address |
| ds_we | output | 1 | Downstream write flag |
| ds_wdata | output | DW | Downstream write data |
| ds_burst | output | BW | Downstream burst length |
| ds_wait | input | 1 | Downstream stall |

## Verification
The hardest case to reach is a burst that is still open when the owner's quota reaches zero while another requester is waiting. Only the burst lock should then keep the grant where it is. The stimulus gives the owner a four-beat burst with a quota of three and keeps a second requester asserted throughout. It checks that the grant stays for the third beat and moves only after the fourth. A stalled beat placed before a quota boundary shows that stalls use no quota. An owner that drops its request while the only other requester sits below it in index order exercises the wrap-around search.

// File: rtl/mem_port_arb_pkg.sv
package mem_port_arb_pkg;

    typedef enum logic [1:0] {
        ARB_STAY    = 2'd0,
        ARB_RELEASE = 2'd1,
        ARB_ROTATE  = 2'd2
    } arb_action_e;

    typedef struct packed {
        arb_action_e action;
        logic        move;
    } arb_decision_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/arb_rr_search.sv
module arb_rr_search #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] base,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = base;
        for (int k = N; k >= 1; k--) begin
            int j;
            j = (int'(base) + k) % N;
            if (cand[j]) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/arb_run_counter.sv
module arb_run_counter #(
    parameter int QUOTA = 4,
    parameter int BW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          done,
    input  logic [BW-1:0] blen,
    output logic          quota_spent_nx,
    output logic          burst_open_nx
);
    localparam int QW = $clog2(QUOTA + 1);

    logic [QW-1:0] quota_q, quota_nx;
    logic [BW-1:0] brem_q, brem_nx;

    always_comb begin
        quota_nx = quota_q;
        brem_nx  = brem_q;
        if (done) begin
            if (quota_q != '0) quota_nx = quota_q - 1'b1;
            if (brem_q != '0)
                brem_nx = brem_q - 1'b1;
            else if (blen != '0)
                brem_nx = blen - 1'b1;
            else
                brem_nx = '0;
        end
        quota_spent_nx = (quota_nx == '0);
        burst_open_nx  = (brem_nx != '0);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            quota_q <= QW'(QUOTA);
            brem_q  <= '0;
        end else begin
            quota_q <= quota_nx;
            brem_q  <= brem_nx;
        end
    end
endmodule

// File: rtl/arb_cmd_mux.sv
module arb_cmd_mux #(
    parameter int N  = 8,
    parameter int IW = 3,
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int BW = 4
) (
    input  logic [IW-1:0]   sel,
    input  logic [N-1:0]    m_xfer,
    input  logic [N*BW-1:0] m_burst,
    input  logic [N*AW-1:0] m_addr,
    input  logic [N-1:0]    m_we,
    input  logic [N*DW-1:0] m_wdata,
    input  logic            ds_wait,
    output logic [N-1:0]    m_wait,
    output logic            ds_valid,
    output logic [AW-1:0]   ds_addr,
    output logic            ds_we,
    output logic [DW-1:0]   ds_wdata,
    output logic [BW-1:0]   ds_burst
);
    always_comb begin
        ds_valid = m_xfer[sel];
        ds_we    = m_we[sel];
        ds_addr  = m_addr[int'(sel)*AW +: AW];
        ds_wdata = m_wdata[int'(sel)*DW +: DW];
        ds_burst = m_burst[int'(sel)*BW +: BW];
    end

    for (genvar i = 0; i < N; i++) begin : g_wait
        assign m_wait[i] = (int'(sel) == i) ? ds_wait : 1'b1;
    end
endmodule

// File: rtl/mem_port_arbiter.sv
module mem_port_arbiter
    import mem_port_arb_pkg::*;
#(
    parameter int N     = 8,
    parameter int QUOTA = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int BW    = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    m_req,
    input  logic [N-1:0]    m_xfer,
    input  logic [N*BW-1:0] m_burst,
    input  logic [N*AW-1:0] m_addr,
    input  logic [N-1:0]    m_we,
    input  logic [N*DW-1:0] m_wdata,
    output logic [N-1:0]    m_grant,
    output logic [N-1:0]    m_wait,
    output logic            ds_valid,
    output logic [AW-1:0]   ds_addr,
    output logic            ds_we,
    output logic [DW-1:0]   ds_wdata,
    output logic [BW-1:0]   ds_burst,
    input  logic            ds_wait
);
    localparam int IW = idx_width(N);

    logic [IW-1:0]  owner_q, next_idx;
    logic [N-1:0]   owner_oh, rivals;
    logic           rival_found, owner_req, done;
    logic           quota_spent_nx, burst_open_nx;
    arb_decision_t  dec;

    always_comb begin
        owner_oh = '0;
        owner_oh[owner_q] = 1'b1;
    end

    assign rivals    = m_req & ~owner_oh;
    assign owner_req = m_req[owner_q];
    assign done      = ds_valid && !ds_wait;

    arb_rr_search #(.N(N), .IW(IW)) u_search (
        .cand  (rivals),
        .base  (owner_q),
        .found (rival_found),
        .idx   (next_idx)
    );

    arb_run_counter #(.QUOTA(QUOTA), .BW(BW)) u_run (
        .clk            (clk),
        .rst            (rst),
        .restart        (dec.move),
        .done           (done),
        .blen           (ds_burst),
        .quota_spent_nx (quota_spent_nx),
        .burst_open_nx  (burst_open_nx)
    );

    always_comb begin
        dec.action = ARB_STAY;
        if (!burst_open_nx && rival_found) begin
            if (!owner_req)
                dec.action = ARB_RELEASE;
            else if (quota_spent_nx)
                dec.action = ARB_ROTATE;
        end
        dec.move = (dec.action != ARB_STAY);
    end

    always_ff @(posedge clk) begin
        if (rst)
            owner_q <= '0;
        else if (dec.move)
            owner_q <= next_idx;
    end

    arb_cmd_mux #(.N(N), .IW(IW), .AW(AW), .DW(DW), .BW(BW)) u_mux (
        .sel      (owner_q),
        .m_xfer   (m_xfer),
        .m_burst  (m_burst),
        .m_addr   (m_addr),
        .m_we     (m_we),
        .m_wdata  (m_wdata),
        .ds_wait  (ds_wait),
        .m_wait   (m_wait),
        .ds_valid (ds_valid),
        .ds_addr  (ds_addr),
        .ds_we    (ds_we),
        .ds_wdata (ds_wdata),
        .ds_burst (ds_burst)
    );

    assign m_grant = owner_oh;
endmodule

// File: rtl/mem_port_arbiter_checker.sv
module mem_port_arbiter_checker #(
    parameter int N     = 8,
    parameter int QUOTA = 4,
    parameter int BW    = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [N-1:0]    m_req,
    input logic [N-1:0]    m_xfer,
    input logic [N*BW-1:0] m_burst,
    input logic [N-1:0]    m_grant,
    input logic [N-1:0]    m_wait,
    input logic            ds_valid,
    input logic            ds_wait
);
    localparam int SW = $clog2(QUOTA + 1) + 1;

    logic [N-1:0]    prev_grant;
    logic [SW-1:0]   served, served_cur, served_nx;
    logic [BW-1:0]   brem, brem_cur, brem_nx, hold_len;
    logic            changed, fin, holder_req, rivals_req;

    always_comb begin
        hold_len = '0;
        for (int i = 0; i < N; i++)
            if (m_grant[i]) hold_len = m_burst[i*BW +: BW];
        changed    = (m_grant != prev_grant);
        fin        = ds_valid && !ds_wait;
        holder_req = |(m_req & m_grant);
        rivals_req = |(m_req & ~m_grant);
        served_cur = changed ? '0 : served;
        brem_cur   = changed ? '0 : brem;
        served_nx  = served_cur;
        if (fin && served_cur < SW'(QUOTA)) served_nx = served_cur + 1'b1;
        brem_nx = brem_cur;
        if (fin) begin
            if (brem_cur != '0)      brem_nx = brem_cur - 1'b1;
            else if (hold_len != '0) brem_nx = hold_len - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_grant <= N'(1);
            served     <= '0;
            brem       <= '0;
        end else begin
            prev_grant <= m_grant;
            served     <= served_nx;
            brem       <= brem_nx;
        end
    end

    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(m_grant) == 1);

    assert_wait_others_R10: assert property (@(posedge clk) disable iff (rst)
        (m_wait | m_grant) == {N{1'b1}});

    assert_wait_owner_R10: assert property (@(posedge clk) disable iff (rst)
        ((m_wait & m_grant) != '0) == ds_wait);

    assert_no_cmd_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (m_xfer == '0) |-> !ds_valid);

    assert_quota_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (holder_req && served_nx < SW'(QUOTA)) |=> $stable(m_grant));

    assert_extend_alone_R6: assert property (@(posedge clk) disable iff (rst)
        (!rivals_req) |=> $stable(m_grant));

    assert_burst_lock_R7: assert property (@(posedge clk) disable iff (rst)
        (brem_nx != '0) |=> $stable(m_grant));

    assert_early_release_R5: assert property (@(posedge clk) disable iff (rst)
        (!holder_req && rivals_req && brem_nx == '0) |=> !$stable(m_grant));
endmodule

bind mem_port_arbiter mem_port_arbiter_checker #(.N(N), .QUOTA(QUOTA), .BW(BW)) u_checker (
    .clk      (clk),
    .rst      (rst),
    .m_req    (m_req),
    .m_xfer   (m_xfer),
    .m_burst  (m_burst),
    .m_grant  (m_grant),
    .m_wait   (m_wait),
    .ds_valid (ds_valid),
    .ds_wait  (ds_wait)
);

// File: tb/mem_port_arbiter_test.sv
module mem_port_arbiter_test;
    localparam int N = 8, QUOTA = 3, AW = 16, DW = 32, BW = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    m_req = '0, m_xfer = '0, m_we = '0;
    logic [N*BW-1:0] m_burst;
    logic [N*AW-1:0] m_addr;
    logic [N*DW-1:0] m_wdata;
    logic [N-1:0]    m_grant, m_wait;
    logic            ds_valid, ds_we;
    logic            ds_wait = 1'b0;
    logic [AW-1:0]   ds_addr;
    logic [DW-1:0]   ds_wdata;
    logic [BW-1:0]   ds_burst;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mem_port_arbiter #(.N(N), .QUOTA(QUOTA), .AW(AW), .DW(DW), .BW(BW)) uut (
        .clk(clk), .rst(rst), .m_req(m_req), .m_xfer(m_xfer), .m_burst(m_burst),
        .m_addr(m_addr), .m_we(m_we), .m_wdata(m_wdata), .m_grant(m_grant),
        .m_wait(m_wait), .ds_valid(ds_valid), .ds_addr(ds_addr), .ds_we(ds_we),
        .ds_wdata(ds_wdata), .ds_burst(ds_burst), .ds_wait(ds_wait)
    );

    // {req[7:0], xfer[7:0], stall[7:0], expected owner index after the edge}
    localparam logic [31:0] VEC [0:15] = '{
        32'h00_00_00_00, // R9 idle hold
        32'h01_01_00_00, // R4 quota 3->2
        32'h21_01_00_00, // R4 quota 2->1, rival waits
        32'h21_01_01_00, // R8 stalled beat uses no quota
        32'h21_01_00_05, // R3 quota spent, next after 0 is 5
        32'h21_20_00_05, // R4
        32'h05_00_00_00, // R5 release, search wraps past 7 to 0
        32'h01_01_00_00, // R4
        32'h01_01_00_00, // R4
        32'h01_01_00_00, // R6 quota spent, nobody else
        32'h01_01_00_00, // R6 beyond quota
        32'h81_01_00_07, // R3 rotate to 7
        32'h83_80_00_07, // R4
        32'h06_00_00_01, // R5 wrap to 1
        32'h00_00_00_01, // R9 hold last owner
        32'h40_00_00_06  // R5 release to 6
    };

    function automatic string vec_tag(input int v);
        case (v)
            0, 14:            return "R9";
            3:                return "R8";
            4, 11:            return "R3";
            6, 13, 15:        return "R5";
            9, 10:            return "R6";
            default:          return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int oh_idx(input logic [N-1:0] v);
        int r = -1;
        for (int i = 0; i < N; i++) if (v[i]) r = i;
        return r;
    endfunction

    initial begin
        for (int i = 0; i < N; i++) begin
            m_addr[i*AW +: AW]   = AW'(16'h1000 + i);
            m_wdata[i*DW +: DW]  = 32'hA000_0000 + i;
            m_burst[i*BW +: BW]  = BW'(1);
            m_we[i]              = i[0];
        end
    end

    initial begin
        repeat (10000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int owner;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        check("R1 grant after reset", 64'(m_grant), 64'h01);
        check("R1 valid after reset", 64'(ds_valid), 64'h0);
        check("R10 wait after reset", 64'(m_wait), 64'hFE);

        owner = 0;
        for (int v = 0; v < 16; v++) begin
            m_req   = VEC[v][31:24];
            m_xfer  = VEC[v][23:16];
            ds_wait = VEC[v][8];
            #2;
            check("R11 valid follows owner strobe", 64'(ds_valid), 64'(m_xfer[owner]));
            check("R11 address of owner", 64'(ds_addr), 64'(16'h1000 + owner));
            @(posedge clk); #1;
            check({vec_tag(v), " grant index"}, 64'(oh_idx(m_grant)), 64'(VEC[v][7:0]));
            owner = int'(VEC[v][7:0]);
        end
        ds_wait = 1'b0;

        // burst lock: owner 6 not requesting, requester 2 takes the port
        m_req = 8'h04; m_xfer = '0;
        @(posedge clk); #1;
        check("R5 move to 2", 64'(oh_idx(m_grant)), 64'd2);

        m_burst[2*BW +: BW] = BW'(4);
        m_req = 8'h14; m_xfer = 8'h04;
        #1;
        check("R11 burst length", 64'(ds_burst), 64'd4);
        check("R11 write data", 64'(ds_wdata), 64'hA000_0002);
        check("R11 write flag", 64'(ds_we), 64'd0);
        for (int b = 1; b <= 3; b++) begin
            @(posedge clk); #1;
            check("R7 burst beat keeps grant", 64'(oh_idx(m_grant)), 64'd2);
        end
        @(posedge clk); #1;
        check("R7 burst end releases to 4", 64'(oh_idx(m_grant)), 64'd4);

        m_xfer = '0; m_req = 8'h10;
        ds_wait = 1'b1; #1;
        check("R10 wait while stalled", 64'(m_wait), 64'hFF);
        ds_wait = 1'b0; #1;
        check("R10 wait while free", 64'(m_wait), 64'hEF);

        // reset again from a non-zero owner
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0; m_req = '0;
        check("R1 grant after second reset", 64'(m_grant), 64'h01);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule